// File: doc/BRIEF.md
# Region Access Permission Checker

This block sits on a memory request path and decides, for each access, whether the access may proceed. Each access carries a 32-bit address and four qualifiers: privileged, write, instruction fetch, and handler context. The block compares the address against up to sixteen configured regions at once. It then returns an allow/fault verdict, a hit flag, the number of the deciding region, and that region's opaque attribute bits, which are passed through unchanged.

A region is a naturally aligned power-of-two window. Its size code `s` gives `2^(s+1)` bytes, and codes 0 to 3 are unusable. Windows of 256 bytes or more are split into eight equal slices, and any slice can be removed from the window with a per-region mask bit. When windows overlap, the region with the highest number decides. Three plain control pins set the global behaviour: a master enable, a background map that lets privileged misses through, and a handler option that puts handler-context accesses under the checks.

Requests enter on a valid/ready stream and verdicts leave on a second valid/ready stream, one cycle after acceptance. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the verdict is held unchanged and no new request is taken. Configuration writes are single-cycle strobes, and a request accepted on the following edge or later sees the new configuration.

Top module: `rgn_guard`

## Requirements
- R1: After reset `rsp_valid` is 0 and every region is disabled. With the master enable set and the background map clear, an unprivileged access therefore faults with `rsp_hit`=0.
- R2: With `ctl_on`=0 every access is allowed, with `rsp_hit`=0, `rsp_region`=0 and `rsp_attr`=0.
- R3: Region n covers the `2^(size+1)` bytes that start at `cfg_base` with its low `size+1` bits cleared. Addresses outside that window do not hit region n.
- R4: A region whose enable is 0, or whose size code is 0, 1, 2 or 3, never hits.
- R5: For size codes of 7 or more, slice k is the k-th eighth of the window, where k = (address offset within the window) / (window bytes / 8). Setting `cfg_srd` bit k removes slice k from the window. For size codes 4 to 6 the mask has no effect.
- R6: When several regions hit, the highest-numbered one supplies the verdict, `rsp_region` and `rsp_attr`.
- R7: The deciding region's `cfg_ap` code sets the permissions. Code 0 or 4: no access. Code 1: privileged read/write only. Code 2: privileged read/write, unprivileged read-only. Code 3: read/write for all. Code 5: privileged read-only. Code 6 or 7: read-only for all.
- R8: A fetch (`req_fetch`=1) from a region with `cfg_xn`=1 faults. Any other fetch is checked as a read, and `req_write` is ignored.
- R9: With no region hit, a privileged access is allowed only if `ctl_bg`=1. An unprivileged access always faults.
- R10: With `ctl_hnd`=0, an access with `req_hctx`=1 is allowed with `rsp_hit`=0. With `ctl_hnd`=1 it is checked like any other access.
- R11: The verdict appears one cycle after acceptance. `req_ready` = !`rsp_valid` || `rsp_ready`. A stalled verdict stays stable.
- R12: On a hit, `rsp_attr` is the deciding region's `cfg_attr`. Without a hit, `rsp_region` and `rsp_attr` are 0.
- R13: `cfg_we`=1 loads every field of region `cfg_idx`. The change applies to requests accepted from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_on | input | 1 | Master enable of region checking |
| ctl_bg | input | 1 | Background map for privileged misses |
| ctl_hnd | input | 1 | Apply checks to handler-context accesses |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | 4 | Region number to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code, window is 2^(code+1) bytes |
| cfg_en | input | 1 | Region enable |
| cfg_srd | input | 8 | Slice removal mask |
| cfg_ap | input | 3 | Permission code |
| cfg_xn | input | 1 | Forbid fetches |
| cfg_attr | input | 6 | Pass-through attribute bits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Access address |
| req_priv | input | 1 | Privileged access |
| req_write | input | 1 | Write access |
| req_fetch | input | 1 | Instruction fetch |
| req_hctx | input | 1 | Fault, non-maskable or masked-handler context |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Consumer takes verdict |
| rsp_allow | output | 1 | 1 allow, 0 fault |
| rsp_hit | output | 1 | Some region decided |
| rsp_region | output | 4 | Deciding region number |
| rsp_attr | output | 6 | Deciding region attribute bits |

## Verification
Some behaviours are checked on every cycle. These are the pass-through when the master enable is off, the handler bypass, the fault on unprivileged misses, and the fault on fetches from fetch-forbidden regions. Also checked on every cycle: verdicts stay frozen under back-pressure, disabled or reserved-size regions never hit, and configuration writes are captured. Other behaviours can only be shown by the bench's scenarios and its reference model. These are slice removal at the eighth boundaries, alignment masking of a misaligned base, highest-number priority across nested windows, and the full permission code table against read, write and privilege.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

  localparam int unsigned SZ_W  = 5;
  localparam int unsigned SRD_W = 8;
  localparam int unsigned AP_W  = 3;

  typedef struct packed {
    logic             en;
    logic [SZ_W-1:0]  size;
    logic [SRD_W-1:0] srd;
    logic [AP_W-1:0]  ap;
    logic             xn;
  } rgn_cfg_t;

  function automatic logic ap_rd_ok(input logic [AP_W-1:0] ap, input logic priv);
    case (ap)
      3'd1, 3'd5:       return priv;
      3'd2, 3'd3,
      3'd6, 3'd7:       return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic ap_wr_ok(input logic [AP_W-1:0] ap, input logic priv);
    case (ap)
      3'd1, 3'd2:       return priv;
      3'd3:             return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rgn_cfg_bank.sv
module rgn_cfg_bank
  import rgn_guard_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned AW     = 32,
  parameter int unsigned ATTR_W = 6,
  localparam int unsigned IDXW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDXW-1:0]               idx,
  input  logic [AW-1:0]                 base,
  input  logic [SZ_W-1:0]               size,
  input  logic                          en,
  input  logic [SRD_W-1:0]              srd,
  input  logic [AP_W-1:0]               ap,
  input  logic                          xn,
  input  logic [ATTR_W-1:0]             attr,
  output logic [NREG-1:0][AW-1:0]       base_q,
  output rgn_cfg_t [NREG-1:0]           cfg_q,
  output logic [NREG-1:0][ATTR_W-1:0]   attr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
      attr_q <= '0;
    end else if (we) begin
      for (int r = 0; r < NREG; r++) begin
        if (idx == IDXW'(r)) begin
          base_q[r]      <= base;
          cfg_q[r].en    <= en;
          cfg_q[r].size  <= size;
          cfg_q[r].srd   <= srd;
          cfg_q[r].ap    <= ap;
          cfg_q[r].xn    <= xn;
          attr_q[r]      <= attr;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDXW'(g)) |=> (base_q[g] == $past(base) && cfg_q[g].ap == $past(ap)
                                   && cfg_q[g].en == $past(en) && attr_q[g] == $past(attr))); // R13
  end

endmodule

// File: rtl/rgn_match_array.sv
module rgn_match_array
  import rgn_guard_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][AW-1:0]  base_q,
  input  rgn_cfg_t [NREG-1:0]      cfg_q,
  output logic [NREG-1:0]          hit_vec
);

  localparam logic [SZ_W-1:0] MIN_CODE   = SZ_W'(4);
  localparam logic [SZ_W-1:0] SLICE_CODE = SZ_W'(7);

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [AW-1:0] keep;
    logic [2:0]    slice;
    logic          size_ok;
    logic          sliced;
    logic          in_win;
    logic          hit;

    always_comb begin
      for (int i = 0; i < AW; i++) begin
        keep[i] = (i > int'(cfg_q[g].size));
      end
      size_ok = cfg_q[g].size >= MIN_CODE;
      sliced  = cfg_q[g].size >= SLICE_CODE;
      slice   = 3'((addr >> (cfg_q[g].size - SZ_W'(2))) & AW'(7));
      in_win  = ((addr ^ base_q[g]) & keep) == '0;
      hit     = cfg_q[g].en && size_ok && in_win && !(sliced && cfg_q[g].srd[slice]);
    end

    assign hit_vec[g] = hit;

    AST_DEAD_RGN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[g].en || cfg_q[g].size < MIN_CODE) |-> !hit_vec[g]); // R4
  end

endmodule

// File: rtl/rgn_prio.sv
module rgn_prio #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0]  hit_vec,
  output logic             any_hit,
  output logic [IDXW-1:0]  sel
);

  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        sel     = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned AW     = 32,
  parameter int unsigned ATTR_W = 6,
  localparam int unsigned IDXW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_on,
  input  logic              ctl_bg,
  input  logic              ctl_hnd,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [AW-1:0]     cfg_base,
  input  logic [SZ_W-1:0]   cfg_size,
  input  logic              cfg_en,
  input  logic [SRD_W-1:0]  cfg_srd,
  input  logic [AP_W-1:0]   cfg_ap,
  input  logic              cfg_xn,
  input  logic [ATTR_W-1:0] cfg_attr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_priv,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_hctx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              rsp_hit,
  output logic [IDXW-1:0]   rsp_region,
  output logic [ATTR_W-1:0] rsp_attr
);

  logic [NREG-1:0][AW-1:0]     base_q;
  rgn_cfg_t [NREG-1:0]         cfg_q;
  logic [NREG-1:0][ATTR_W-1:0] attr_q;
  logic [NREG-1:0]             hit_vec;
  logic                        any_hit;
  logic [IDXW-1:0]             sel;

  rgn_cfg_bank #(.NREG(NREG), .AW(AW), .ATTR_W(ATTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .base(cfg_base),
    .size(cfg_size), .en(cfg_en), .srd(cfg_srd), .ap(cfg_ap), .xn(cfg_xn),
    .attr(cfg_attr), .base_q(base_q), .cfg_q(cfg_q), .attr_q(attr_q)
  );

  rgn_match_array #(.NREG(NREG), .AW(AW)) u_match (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .base_q(base_q),
    .cfg_q(cfg_q), .hit_vec(hit_vec)
  );

  rgn_prio #(.NREG(NREG)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .sel(sel)
  );

  logic              bypass;
  logic              fire;
  logic              dec_allow;
  logic              dec_hit;
  logic [IDXW-1:0]   dec_region;
  logic [ATTR_W-1:0] dec_attr;
  rgn_cfg_t          win;

  assign bypass    = !ctl_on || (req_hctx && !ctl_hnd);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign win       = cfg_q[sel];

  always_comb begin
    dec_allow  = 1'b1;
    dec_hit    = 1'b0;
    dec_region = '0;
    dec_attr   = '0;
    if (!bypass) begin
      if (any_hit) begin
        dec_hit    = 1'b1;
        dec_region = sel;
        dec_attr   = attr_q[sel];
        if (req_fetch)      dec_allow = !win.xn && ap_rd_ok(win.ap, req_priv);
        else if (req_write) dec_allow = ap_wr_ok(win.ap, req_priv);
        else                dec_allow = ap_rd_ok(win.ap, req_priv);
      end else begin
        dec_allow = req_priv && ctl_bg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_attr   <= '0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_allow  <= dec_allow;
      rsp_hit    <= dec_hit;
      rsp_region <= dec_region;
      rsp_attr   <= dec_attr;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctl_on) |=> (rsp_valid && rsp_allow && !rsp_hit)); // R2
  AST_HCTX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl_on && req_hctx && !ctl_hnd) |=> (rsp_allow && !rsp_hit)); // R10
  AST_USER_MISS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bypass && !req_priv && hit_vec == '0) |=> !rsp_allow); // R9
  AST_XN_FETCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bypass && any_hit && req_fetch && cfg_q[sel].xn) |=> !rsp_allow); // R8
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow) && $stable(rsp_hit)
                                   && $stable(rsp_region) && $stable(rsp_attr))); // R11
  AST_MISS_ZERO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_region == '0 && rsp_attr == '0)); // R12

endmodule

// File: tb/tb_rgn_guard.sv
`timescale 1ns/1ps
module tb_rgn_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ctl_on = 1'b0, ctl_bg = 1'b0, ctl_hnd = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [4:0] cfg_size = '0;
  logic cfg_en = 1'b0;
  logic [7:0] cfg_srd = '0;
  logic [2:0] cfg_ap = '0;
  logic cfg_xn = 1'b0;
  logic [5:0] cfg_attr = '0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic req_priv = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_hctx = 1'b0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_allow, rsp_hit;
  logic [3:0] rsp_region;
  logic [5:0] rsp_attr;

  rgn_guard dut (
    .clk(clk), .rst_n(rst_n), .ctl_on(ctl_on), .ctl_bg(ctl_bg), .ctl_hnd(ctl_hnd),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_en(cfg_en), .cfg_srd(cfg_srd), .cfg_ap(cfg_ap), .cfg_xn(cfg_xn),
    .cfg_attr(cfg_attr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_priv(req_priv), .req_write(req_write),
    .req_fetch(req_fetch), .req_hctx(req_hctx), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_attr(rsp_attr)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] m_base [16];
  int          m_size [16];
  bit          m_en   [16];
  logic [7:0]  m_srd  [16];
  int          m_ap   [16];
  bit          m_xn   [16];
  logic [5:0]  m_attr [16];

  typedef struct {
    bit         al;
    bit         ht;
    int         rg;
    logic [5:0] at;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  function automatic exp_t ref_decide(input logic [31:0] a, input bit pv, input bit wr,
                                       input bit fe, input bit hc);
    exp_t e;
    bit rd_ok, wr_ok;
    e.al = 1'b1; e.ht = 1'b0; e.rg = 0; e.at = '0;
    if (!ctl_on || (hc && !ctl_hnd)) return e;
    for (int r = 0; r < 16; r++) begin
      longint bytes, lo, off;
      if (!m_en[r] || m_size[r] < 4) continue;
      bytes = longint'(1) << (m_size[r] + 1);
      lo    = longint'(m_base[r]) - (longint'(m_base[r]) % bytes);
      off   = longint'(a) - lo;
      if (off < 0 || off >= bytes) continue;
      if (m_size[r] >= 7 && m_srd[r][int'(off / (bytes / 8))]) continue;
      e.ht = 1'b1; e.rg = r; e.at = m_attr[r];
    end
    if (!e.ht) begin
      e.al = pv && ctl_bg;
      return e;
    end
    case (m_ap[e.rg])
      1: begin rd_ok = pv;   wr_ok = pv;   end
      2: begin rd_ok = 1'b1; wr_ok = pv;   end
      3: begin rd_ok = 1'b1; wr_ok = 1'b1; end
      5: begin rd_ok = pv;   wr_ok = 1'b0; end
      6, 7: begin rd_ok = 1'b1; wr_ok = 1'b0; end
      default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
    endcase
    if (fe)      e.al = rd_ok && !m_xn[e.rg];
    else if (wr) e.al = wr_ok;
    else         e.al = rd_ok;
    return e;
  endfunction

  task automatic wcfg(input int idx, input logic [31:0] base, input int size, input bit en,
                      input logic [7:0] srd, input int ap, input bit xn, input logic [5:0] attr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_base = base; cfg_size = 5'(size);
    cfg_en = en; cfg_srd = srd; cfg_ap = 3'(ap); cfg_xn = xn; cfg_attr = attr;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[idx] = base; m_size[idx] = size; m_en[idx] = en; m_srd[idx] = srd;
    m_ap[idx] = ap; m_xn[idx] = xn; m_attr[idx] = attr;
  endtask

  task automatic drive(input logic [31:0] a, input bit pv, input bit wr, input bit fe, input bit hc);
    req_valid = 1'b1; req_addr = a; req_priv = pv; req_write = wr; req_fetch = fe; req_hctx = hc;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input bit pv, input bit wr,
                       input bit fe, input bit hc, input bit e_al, input bit e_ht,
                       input int e_rg, input logic [5:0] e_at);
    @(negedge clk);
    rsp_ready = 1'b1;
    drive(a, pv, wr, fe, hc);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tag, "rsp_allow", 32'(rsp_allow), 32'(e_al));
    chk(tag, "rsp_hit", 32'(rsp_hit), 32'(e_ht));
    chk(tag, "rsp_region", 32'(rsp_region), 32'(e_rg));
    chk(tag, "rsp_attr", 32'(rsp_attr), 32'(e_at));
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin
      m_base[r] = '0; m_size[r] = 0; m_en[r] = 1'b0; m_srd[r] = '0;
      m_ap[r] = 0; m_xn[r] = 1'b0; m_attr[r] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    ctl_on = 1'b1; ctl_bg = 1'b0; ctl_hnd = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    probe("R1", 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 6'h00);

    ctl_on = 1'b0;
    probe("R2", 32'h0000_1000, 0, 1, 0, 0, 1, 0, 0, 6'h00);
    ctl_on = 1'b1;

    // region 0: 64 KB at 0x2000_0000, full access
    wcfg(0, 32'h2000_0000, 15, 1, 8'h00, 3, 0, 6'h11);
    probe("R3_R13_R12", 32'h2000_FFFC, 0, 1, 0, 0, 1, 1, 0, 6'h11);
    probe("R3_outside", 32'h2001_0000, 0, 0, 0, 0, 0, 0, 0, 6'h00);

    // region 1: 256 B, misaligned base, slice 2 removed, privileged only
    wcfg(1, 32'h2000_0123, 7, 1, 8'b0000_0100, 1, 0, 6'h22);
    probe("R3_R6_align", 32'h2000_0110, 1, 1, 0, 0, 1, 1, 1, 6'h22);
    probe("R7_ap1_user", 32'h2000_0110, 0, 0, 0, 0, 0, 1, 1, 6'h22);
    probe("R5_slice_removed", 32'h2000_0150, 0, 1, 0, 0, 1, 1, 0, 6'h11);
    probe("R5_slice_kept", 32'h2000_0160, 1, 0, 0, 0, 1, 1, 1, 6'h22);

    // region 2: 32 B with full mask (mask ignored), read-only for all
    wcfg(2, 32'h3000_0000, 4, 1, 8'hFF, 6, 0, 6'h33);
    probe("R5_small_mask_ignored", 32'h3000_0004, 0, 0, 0, 0, 1, 1, 2, 6'h33);
    probe("R7_ap6_write", 32'h3000_0004, 1, 1, 0, 0, 0, 1, 2, 6'h33);

    // region 3 reserved size, region 4 disabled
    wcfg(3, 32'h4000_0000, 3, 1, 8'h00, 3, 0, 6'h01);
    probe("R4_reserved_size", 32'h4000_0000, 0, 0, 0, 0, 0, 0, 0, 6'h00);
    wcfg(4, 32'h5000_0000, 9, 0, 8'h00, 3, 0, 6'h02);
    probe("R4_disabled", 32'h5000_0010, 0, 0, 0, 0, 0, 0, 0, 6'h00);

    // region 5: 4 KB over 0 and 1, privileged read-only, fetch forbidden
    wcfg(5, 32'h2000_0000, 11, 1, 8'h00, 5, 1, 6'h05);
    probe("R6_highest_wins", 32'h2000_0110, 1, 0, 0, 0, 1, 1, 5, 6'h05);
    probe("R7_ap5_write", 32'h2000_0110, 1, 1, 0, 0, 0, 1, 5, 6'h05);
    probe("R8_xn_fetch", 32'h2000_0400, 1, 0, 1, 0, 0, 1, 5, 6'h05);
    probe("R8_fetch_ok", 32'h2000_2000, 0, 1, 1, 0, 1, 1, 0, 6'h11);

    // permission codes on region 2
    wcfg(2, 32'h3000_0000, 4, 1, 8'h00, 2, 0, 6'h33);
    probe("R7_ap2_user_rd", 32'h3000_0008, 0, 0, 0, 0, 1, 1, 2, 6'h33);
    probe("R7_ap2_user_wr", 32'h3000_0008, 0, 1, 0, 0, 0, 1, 2, 6'h33);
    probe("R7_ap2_priv_wr", 32'h3000_0008, 1, 1, 0, 0, 1, 1, 2, 6'h33);
    wcfg(2, 32'h3000_0000, 4, 1, 8'h00, 0, 0, 6'h33);
    probe("R7_ap0_priv_rd", 32'h3000_0008, 1, 0, 0, 0, 0, 1, 2, 6'h33);
    wcfg(2, 32'h3000_0000, 4, 1, 8'h00, 4, 0, 6'h33);
    probe("R7_ap4_priv_rd", 32'h3000_0008, 1, 0, 0, 0, 0, 1, 2, 6'h33);
    wcfg(2, 32'h3000_0000, 4, 1, 8'h00, 7, 0, 6'h33);
    probe("R7_ap7_user_rd", 32'h3000_0008, 0, 0, 0, 0, 1, 1, 2, 6'h33);
    probe("R7_ap7_priv_wr", 32'h3000_0008, 1, 1, 0, 0, 0, 1, 2, 6'h33);

    // background map
    ctl_bg = 1'b1;
    probe("R9_bg_priv", 32'h7000_0000, 1, 1, 0, 0, 1, 0, 0, 6'h00);
    probe("R9_bg_user", 32'h7000_0000, 0, 0, 0, 0, 0, 0, 0, 6'h00);
    ctl_bg = 1'b0;
    probe("R9_nobg_priv", 32'h7000_0000, 1, 0, 0, 0, 0, 0, 0, 6'h00);

    // handler context
    ctl_hnd = 1'b0;
    probe("R10_bypass", 32'h2000_0400, 0, 1, 1, 1, 1, 0, 0, 6'h00);
    ctl_hnd = 1'b1;
    probe("R10_checked", 32'h2000_0400, 0, 1, 0, 1, 0, 1, 5, 6'h05);

    // back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(32'h2000_2000, 1, 0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    drive(32'h7000_0000, 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) begin
      chk("R11_stall", "req_ready", 32'(req_ready), 32'd0);
      chk("R11_stall", "rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R11_stall", "rsp_region", 32'(rsp_region), 32'd0);
      chk("R11_stall", "rsp_attr", 32'(rsp_attr), 32'h11);
      chk("R11_stall", "rsp_allow", 32'(rsp_allow), 32'd1);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11_second", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R11_second", "rsp_allow", 32'(rsp_allow), 32'd0);
    chk("R11_second", "rsp_hit", 32'(rsp_hit), 32'd0);
    @(negedge clk);
    chk("R11_drain", "rsp_valid", 32'(rsp_valid), 32'd0);

    // random streaming against the model, compared every clock
    for (int round = 0; round < 4; round++) begin
      for (int r = 0; r < 16; r++) begin
        wcfg(r, $urandom & 32'hFFFF_FFF0 | (round[0] ? 32'h0 : 32'h2000_0000 & 32'hF000_0000),
             $urandom_range(2, 20), ($urandom % 5) != 0, 8'($urandom), $urandom % 8,
             $urandom % 2, 6'($urandom));
      end
      ctl_on = (round != 3); ctl_bg = round[0]; ctl_hnd = round[1];
      for (int cyc = 0; cyc < 1500; cyc++) begin
        exp_t e;
        bit do_pop, do_push;
        int pick;
        logic [31:0] a;
        @(negedge clk);
        chk("R11_stream", "rsp_valid", 32'(rsp_valid), 32'(q.size() > 0));
        if (rsp_valid && q.size() > 0) begin
          chk("R3_R5_R6_R7_stream", "rsp_allow", 32'(rsp_allow), 32'(q[0].al));
          chk("R6_R12_stream", "rsp_hit", 32'(rsp_hit), 32'(q[0].ht));
          chk("R6_R12_stream", "rsp_region", 32'(rsp_region), 32'(q[0].rg));
          chk("R12_stream", "rsp_attr", 32'(rsp_attr), 32'(q[0].at));
        end
        rsp_ready = ($urandom % 4) != 0;
        pick = $urandom % 16;
        if (($urandom % 4) == 0) a = $urandom;
        else a = m_base[pick] ^ ($urandom & ((32'h1 << (m_size[pick] + 2)) - 1));
        drive(a, $urandom % 2, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0);
        req_valid = ($urandom % 3) != 0;
        #1;
        do_pop  = rsp_valid && rsp_ready;
        do_push = req_valid && req_ready;
        if (do_push) e = ref_decide(req_addr, req_priv, req_write, req_fetch, req_hctx);
        if (do_pop && q.size() > 0) void'(q.pop_front());
        if (do_push) q.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      repeat (3) @(negedge clk);
      q.delete();
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule